// File: doc/BRIEF.md
# FSK Tone Synthesizer for a 300-Baud Modem

This block is the transmit half of a low-speed frequency-shift-keying modem. From a colour-burst master clock (3.579545 MHz by default) it divides down to a sampling rate near 77.82 kHz. On each sample period it advances a phase accumulator by a tuning word and turns the phase into a signed sine sample. Three control pins choose the tuning word: the line standard (the US 103-style plan or the V.21 plan), the call direction (originate or answer), and the transmit data bit (mark or space). The tone stays phase-continuous when any of these pins changes. Every output frequency scales with the master clock.

Samples leave on a valid/ready stream towards a DAC or a smoothing-filter stage. There is no back-pressure into the synthesizer, because the carrier must keep real time. A sample that has not been taken stays on the port, unchanged, until the consumer raises ready. If the next sample period arrives first, the newer sample replaces the held one and valid stays high. A consumer that keeps ready high sees valid as a one-cycle pulse every sample period.

Two pins make the line silent. Squelch lets the phase keep running but forces the samples to zero, so the line driver can carry some other signal. Power-down also forces zero, and it freezes the phase as well. Samples keep arriving at the normal rate in both cases.

Top module: `fsk_tone_synth`

## Requirements
- R1: A sample period is exactly SAMPLE_DIV (default 46) clock cycles. The first sample is produced on the SAMPLE_DIV-th rising edge after reset is released.
- R2: The tone is selected by index {std_v21, answer_mode, tx_bit}, where tx_bit=1 means mark. The eight tones in Hz are: 0:1070, 1:1270, 2:2025, 3:2225, 4:1180, 5:980, 6:1850, 7:1650.
- R3: Each tuning word is round(f * 2^ACC_W * SAMPLE_DIV / CLK_HZ) with ACC_W=24, which keeps the synthesized frequency within 1 Hz of nominal.
- R4: A sample is round(127*sin(2*pi*(p+0.5)/256)), where p is the top 8 bits of the phase. The result is 8-bit two's complement and never takes the code 0x80.
- R5: A sample is computed from the phase held before that period's update. The phase then adds the tuning word, modulo 2^24.
- R6: A change of tx_bit, answer_mode or std_v21 changes only the tuning word and never resets the phase.
- R7: When squelch is high at a sample edge, that sample is 0 and the phase still advances.
- R8: When power_down is high at a sample edge, that sample is 0 and the phase is held. Once power_down is released, the tone resumes from the held phase.
- R9: out_valid keeps being raised every sample period while squelch or power_down is active.
- R10: out_valid rises at a sample edge. out_data then stays stable while out_valid is high and out_ready is low. out_valid falls in the cycle after out_valid and out_ready are both high, unless a new sample period overwrites the held sample in that cycle.
- R11: Reset (rst_n low, asynchronous) clears out_valid, out_data, the phase and the divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (nominal 3.579545 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_bit | input | 1 | Data bit to send: 1 mark, 0 space |
| answer_mode | input | 1 | 1 selects the answer-side tones, 0 the originate-side tones |
| std_v21 | input | 1 | 1 selects the V.21 tone plan, 0 the 103-style plan |
| squelch | input | 1 | Forces zero samples while the phase keeps running |
| power_down | input | 1 | Forces zero samples and freezes the phase |
| out_ready | input | 1 | Consumer accepts the held sample |
| out_valid | output | 1 | A sample is held on out_data |
| out_data | output | SAMPLE_W (8) | Signed sine sample |

## Verification
Several properties are checked on every cycle: the spacing of sample periods, the valid/ready hold and release rules, zero output at silent sample edges, a phase that changes only at non-powered-down sample edges and always advances there, and the absence of the code 0x80. The exact sample values can only be shown by the bench's reference model, which it compares on every clock. Those values depend on the tuning-word rounding, the sine table, the phase continuity across data and mode changes, and the phase resuming after power-down. The bench runs all eight tones, mid-period changes of the select pins, and ready patterns that exercise both hold and overwrite.

// File: rtl/fsk_synth_pkg.sv
`timescale 1ns/1ps
package fsk_synth_pkg;

  localparam int TONE_COUNT = 8;

  // Tone selector; the packed order {std_v21, answer, mark} forms the table index.
  typedef struct packed {
    logic std_v21;
    logic answer;
    logic mark;
  } tone_key_t;

  // Nominal transmit frequencies in Hz, indexed by tone_key_t.
  function automatic int nominal_hz(int key);
    case (key)
      0:       return 1070;
      1:       return 1270;
      2:       return 2025;
      3:       return 2225;
      4:       return 1180;
      5:       return 980;
      6:       return 1850;
      default: return 1650;
    endcase
  endfunction

  // Nearest phase increment per sample for tone hz at clock clk_hz / div.
  function automatic longint tuning_word(int hz, longint clk_hz, int div, int acc_w);
    longint num;
    num = (longint'(hz) * longint'(div) * 64'sd2) <<< acc_w;
    return (num + clk_hz) / (64'sd2 * clk_hz);
  endfunction

  // Quarter-wave sample at half-step offset: round(amp*sin(pi/2*(idx+0.5)/n)).
  function automatic int quarter_sine(int idx, int n, int amp);
    real x;
    x = 1.5707963267948966 * (real'(idx) + 0.5) / real'(n);
    return $rtoi(real'(amp) * $sin(x) + 0.5);
  endfunction

endpackage

// File: rtl/fsk_tick_gen.sv
`timescale 1ns/1ps
module fsk_tick_gen #(
  parameter int DIV = 46
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/fsk_tone_rom.sv
`timescale 1ns/1ps
module fsk_tone_rom
  import fsk_synth_pkg::*;
#(
  parameter longint CLK_HZ = 3579545,
  parameter int     DIV    = 46,
  parameter int     ACC_W  = 24
) (
  input  tone_key_t        key,
  output logic [ACC_W-1:0] word
);
  logic [ACC_W-1:0] words [TONE_COUNT];

  for (genvar k = 0; k < TONE_COUNT; k++) begin : g_word
    localparam longint W = tuning_word(nominal_hz(k), CLK_HZ, DIV, ACC_W);
    assign words[k] = W[ACC_W-1:0];
  end

  assign word = words[{key.std_v21, key.answer, key.mark}];
endmodule

// File: rtl/fsk_phase_acc.sv
`timescale 1ns/1ps
module fsk_phase_acc #(
  parameter int ACC_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             freeze,
  input  logic [ACC_W-1:0] step,
  output logic [ACC_W-1:0] phase
);
  logic [ACC_W-1:0] acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                acc_q <= '0;
    else if (tick && !freeze)  acc_q <= acc_q + step;
  end

  assign phase = acc_q;
endmodule

// File: rtl/fsk_quarter_sine.sv
`timescale 1ns/1ps
module fsk_quarter_sine
  import fsk_synth_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int SAMPLE_W = 8
) (
  input  logic [ADDR_W+1:0]   angle,
  output logic [SAMPLE_W-1:0] sample
);
  localparam int N   = 1 << ADDR_W;
  localparam int AMP = (1 << (SAMPLE_W - 1)) - 1;

  logic [SAMPLE_W-2:0] tbl [N];

  for (genvar i = 0; i < N; i++) begin : g_tbl
    localparam int V = quarter_sine(i, N, AMP);
    assign tbl[i] = V[SAMPLE_W-2:0];
  end

  logic [1:0]          quad;
  logic [ADDR_W-1:0]   off;
  logic [ADDR_W-1:0]   addr;
  logic [SAMPLE_W-1:0] mag;

  assign quad   = angle[ADDR_W+1:ADDR_W];
  assign off    = angle[ADDR_W-1:0];
  assign addr   = quad[0] ? ~off : off;
  assign mag    = {1'b0, tbl[addr]};
  assign sample = quad[1] ? (~mag + 1'b1) : mag;
endmodule

// File: rtl/fsk_tone_synth.sv
`timescale 1ns/1ps
module fsk_tone_synth
  import fsk_synth_pkg::*;
#(
  parameter longint CLK_HZ     = 3579545,
  parameter int     SAMPLE_DIV = 46,
  parameter int     ACC_W      = 24,
  parameter int     LUT_ADDR_W = 6,
  parameter int     SAMPLE_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tx_bit,
  input  logic                answer_mode,
  input  logic                std_v21,
  input  logic                squelch,
  input  logic                power_down,
  input  logic                out_ready,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_data
);
  localparam int ANGLE_W = LUT_ADDR_W + 2;

  logic                smp_tick;
  logic [ACC_W-1:0]    step_w;
  logic [ACC_W-1:0]    phase_q;
  logic [SAMPLE_W-1:0] wave;
  logic                silent;
  tone_key_t           key;

  assign key    = '{std_v21: std_v21, answer: answer_mode, mark: tx_bit};
  assign silent = squelch | power_down;

  fsk_tick_gen #(.DIV(SAMPLE_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (smp_tick)
  );

  fsk_tone_rom #(.CLK_HZ(CLK_HZ), .DIV(SAMPLE_DIV), .ACC_W(ACC_W)) u_rom (
    .key (key),
    .word(step_w)
  );

  fsk_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (smp_tick),
    .freeze(power_down),
    .step  (step_w),
    .phase (phase_q)
  );

  fsk_quarter_sine #(.ADDR_W(LUT_ADDR_W), .SAMPLE_W(SAMPLE_W)) u_sine (
    .angle (phase_q[ACC_W-1 -: ANGLE_W]),
    .sample(wave)
  );

  // Output holding register: a new period overwrites, acceptance clears.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (smp_tick) begin
      out_valid <= 1'b1;
      out_data  <= silent ? '0 : wave;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/fsk_tone_synth_chk.sv
`timescale 1ns/1ps
module fsk_tone_synth_chk #(
  parameter int DIV      = 46,
  parameter int ACC_W    = 24,
  parameter int SAMPLE_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                tick,
  input logic                squelch,
  input logic                power_down,
  input logic                out_ready,
  input logic                out_valid,
  input logic [ACC_W-1:0]    phase,
  input logic [SAMPLE_W-1:0] out_data
);
  localparam int GW = $clog2(DIV) + 1;
  localparam logic [SAMPLE_W-1:0] MIN_CODE = {1'b1, {(SAMPLE_W-1){1'b0}}};

  logic [GW-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    gap_q <= '0;
    else if (tick) gap_q <= '0;
    else           gap_q <= gap_q + 1'b1;
  end

  AST_TICK_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> gap_q == GW'(DIV - 1)); // R1
  AST_VALID_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> out_valid); // R10
  AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !tick |=> out_valid && $stable(out_data)); // R10
  AST_DROP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !tick |=> !out_valid); // R10
  AST_SILENT_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    tick && (squelch || power_down) |=> out_data == '0); // R7
  AST_PHASE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick || power_down) |=> $stable(phase)); // R8
  AST_PHASE_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !power_down |=> !$stable(phase)); // R7
  AST_NO_MIN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_data != MIN_CODE); // R4
endmodule

bind fsk_tone_synth fsk_tone_synth_chk #(
  .DIV(SAMPLE_DIV), .ACC_W(ACC_W), .SAMPLE_W(SAMPLE_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (smp_tick),
  .squelch   (squelch),
  .power_down(power_down),
  .out_ready (out_ready),
  .out_valid (out_valid),
  .phase     (phase_q),
  .out_data  (out_data)
);

// File: tb/fsk_tone_synth_tb.sv
`timescale 1ns/1ps
module fsk_tone_synth_tb;
  localparam longint CLK_NOM = 3579545;
  localparam int     DIVN    = 46;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_bit = 1'b0, answer_mode = 1'b0, std_v21 = 1'b0;
  logic       squelch = 1'b0, power_down = 1'b0, out_ready = 1'b1;
  logic       out_valid;
  logic [7:0] out_data;

  int    compared = 0;
  int    mismatched = 0;
  bit    finished = 1'b0;
  string cur_req = "R11";

  // reference model state
  int     m_cnt = 0;
  longint m_ph = 0;
  bit     m_valid = 1'b0;
  int     m_data = 0;

  always #2.5 clk = ~clk;

  fsk_tone_synth u_dut (
    .clk(clk), .rst_n(rst_n), .tx_bit(tx_bit), .answer_mode(answer_mode),
    .std_v21(std_v21), .squelch(squelch), .power_down(power_down),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data)
  );

  function automatic longint tone_ref(bit v21, bit ans, bit mark);
    if (!v21) return ans ? (mark ? 2225 : 2025) : (mark ? 1270 : 1070);
    else      return ans ? (mark ? 1650 : 1850) : (mark ? 980 : 1180);
  endfunction

  function automatic longint step_ref(bit v21, bit ans, bit mark);
    longint f;
    f = tone_ref(v21, ans, mark);
    return (f * DIVN * (64'sd1 << 24) + CLK_NOM / 2) / CLK_NOM;
  endfunction

  function automatic int sine_ref(longint p8);
    real s, m;
    s = $sin(6.283185307179586 * (real'(p8) + 0.5) / 256.0);
    m = $floor(127.0 * (s < 0.0 ? -s : s) + 0.5);
    return (s < 0.0) ? -$rtoi(m) : $rtoi(m);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural model, stepped on each rising edge.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_ph = 0; m_valid = 1'b0; m_data = 0;
    end else begin
      if (m_cnt == DIVN - 1) begin
        m_cnt   = 0;
        m_valid = 1'b1;
        m_data  = (squelch || power_down) ? 0 : sine_ref(m_ph >> 16);
        if (!power_down)
          m_ph = (m_ph + step_ref(std_v21, answer_mode, tx_bit)) % (64'sd1 << 24);
      end else begin
        m_cnt = m_cnt + 1;
        if (m_valid && out_ready) m_valid = 1'b0;
      end
    end
  end

  // Compare on every falling edge once out of reset.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(out_valid == m_valid, {cur_req, " valid"}, int'(out_valid), int'(m_valid));
      check($signed(out_data) == m_data, {cur_req, " data"}, int'($signed(out_data)), m_data);
    end
  end

  task automatic run(int cycles, int rmode);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      case (rmode)
        0:       out_ready = 1'b1;
        1:       out_ready = ((i / 7) % 2) == 0;
        default: out_ready = 1'b0;
      endcase
    end
  endtask

  task automatic measure_gap(string req);
    int n;
    out_ready = 1'b1;
    while (!out_valid) @(negedge clk);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!out_valid);
    check(n == DIVN, req, n, DIVN);
  endtask

  task automatic toggle_bits(int count, int spacing);
    for (int t = 0; t < count; t++) begin
      tx_bit = ~tx_bit;
      run(spacing, 0);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R11: outputs clear while held in reset
    check(out_valid == 1'b0, "R11 reset valid", int'(out_valid), 0);
    check(out_data == 8'd0, "R11 reset data", int'(out_data), 0);
    rst_n = 1'b1;

    cur_req = "R1 R5";
    measure_gap("R1 period");
    measure_gap("R1 period");

    cur_req = "R2 R3 R4 R5 originate 103";
    tx_bit = 1'b0; run(20 * DIVN, 0);
    tx_bit = 1'b1; run(20 * DIVN + 17, 0);

    cur_req = "R2 R3 R6 answer 103";
    answer_mode = 1'b1; toggle_bits(30, 101);

    cur_req = "R2 R3 R6 originate V21";
    std_v21 = 1'b1; answer_mode = 1'b0; toggle_bits(30, 97);

    cur_req = "R2 R3 R6 answer V21";
    answer_mode = 1'b1; toggle_bits(30, 131);

    cur_req = "R6 mode switch";
    for (int k = 0; k < 8; k++) begin
      {std_v21, answer_mode, tx_bit} = 3'(k);
      run(3 * DIVN + 11, 0);
    end

    cur_req = "R7 R9 squelch";
    squelch = 1'b1; run(15 * DIVN, 0);
    measure_gap("R9 squelch period");
    squelch = 1'b0; run(10 * DIVN, 0);

    cur_req = "R8 R9 power down";
    power_down = 1'b1; run(15 * DIVN + 5, 0);
    measure_gap("R9 power-down period");
    power_down = 1'b0; run(10 * DIVN, 0);

    cur_req = "R10 ready gaps";
    run(30 * DIVN, 1);
    cur_req = "R10 overwrite";
    run(3 * DIVN + 10, 2);
    run(4 * DIVN, 0);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule